// File: doc/BRIEF.md
# Class-of-Service Cache Mask Table

This block keeps the cache allocation bitmasks for two cache levels, one set per class-of-service ID. A write port takes a register address and a mask. The address selects a level and an entry. A mask is accepted only if it is one unbroken run of set bits that fits within that level's bit length. A lookup port takes a class-of-service ID and a code/data fetch flag. It returns, combinationally, the mid-level and last-level allocation masks that the replacement logic should enforce for that request.

Entry 0 of each level always holds the all-ones default mask. When an ID is beyond a level's entry count, that level answers with its default mask. A mode bit, loaded through its own strobe, splits the last-level table. Each usable ID then owns two registers: the even one is used for data fetches and the odd one for code fetches. Only the lower half of the ID range remains usable at that level. Switching the mode does not change stored contents, so masks written before a switch reappear when the mode is switched back.

Top module: `clos_mask_table`

## Requirements
- R1: Reset is synchronous and active high. After reset, every entry of both levels holds its default mask, split mode is off and `wr_err` is 0.
- R2: A level's default mask is all ones across its configured length: 0xFF for the 8-bit mid level and 0xFFF for the 12-bit last level.
- R3: A legal write to address 0xC90+n, with 1 <= n < 16, stores the mask in last-level register n. With split mode off, a lookup of ID n returns it from the cycle after the write.
- R4: A legal write to address 0xD10+n, with 1 <= n < 8, stores the mask in mid-level entry n. A lookup of ID n returns it from the cycle after the write.
- R5: A mask is rejected and leaves every entry unchanged in three cases: it is zero, it contains more than one run of ones, or it has a bit set at or above the target level's length.
- R6: Writes to register 0 of either level (0xC90, 0xD10) are rejected. A lookup of ID 0 returns both default masks in every mode.
- R7: A write to an address outside both register ranges is rejected and changes nothing.
- R8: A lookup ID of 8 or more returns the mid-level default. The last level still returns its own stored entry for that ID.
- R9: With split mode off, the code/data flag has no effect on either output.
- R10: With split mode on, for 1 <= n < 8, ID n returns last-level register 2n when the flag is 0 (data) and register 2n+1 when it is 1 (code). IDs 8 and above return the last-level default. The mid level is unaffected by the mode.
- R11: When `mode_wr` is high, the split-mode bit loads `mode_val`. The new mode applies from the next cycle, and toggling the mode leaves stored masks intact.
- R12: `wr_err` is high in the cycle after each rejected write. It is low in the cycle after an accepted write or after a cycle with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Register address |
| wr_data | input | 12 | Mask to write |
| mode_wr | input | 1 | Load strobe for the split-mode bit |
| mode_val | input | 1 | Split-mode value to load |
| lk_id | input | 4 | Class-of-service ID of the request |
| lk_code | input | 1 | 1 = code fetch, 0 = data fetch |
| l2_mask | output | 8 | Mid-level allocation mask |
| l3_mask | output | 12 | Last-level allocation mask |
| wr_err | output | 1 | One-cycle flag for a rejected write |

## Verification
The hardest case to reach from the ports is split mode. There, the data and code masks for one ID live in two neighbouring registers, and ID 0's partner register holds a mask that must never be returned. The stimulus handles this in three steps. First, it writes distinct legal masks into an even/odd register pair and into register 1 while the mode is off. It then turns the mode on and looks up with both flag values, including ID 0 and IDs in the upper half of the range. Finally, it turns the mode off and checks that the plain single-mask view of the same registers returns unchanged.

// File: rtl/cmask_pkg.sv
package cmask_pkg;

  // True when m is non-zero and its set bits form one unbroken run.
  function automatic logic run_ok(input logic [31:0] m);
    logic [31:0] low;
    logic [31:0] sum;
    low = m & (~m + 32'd1);
    sum = m + low;
    return (m != 32'd0) && ((sum & m) == 32'd0);
  endfunction

endpackage

// File: rtl/cmask_bank.sv
module cmask_bank #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] wr_idx,
  input  logic [W-1:0]             wr_val,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [W-1:0]             rd_val
);
  localparam int IW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (we) begin
      mem[wr_idx] <= wr_val;
    end
  end

  assign rd_val = mem[rd_idx];

  // R3
  store_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(wr_idx)] == $past(wr_val));

  // R6
  pin0_chk: assert property (@(posedge clk) disable iff (rst)
    mem[IW'(0)] == {W{1'b1}});

endmodule

// File: rtl/cmask_decode.sv
module cmask_decode
  import cmask_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int MASK_W  = 12,
  parameter int L2_LEN  = 8,
  parameter int L3_LEN  = 12,
  parameter int L2_N    = 8,
  parameter int L3_N    = 16,
  parameter int L2_BASE = 'hD10,
  parameter int L3_BASE = 'hC90
) (
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [MASK_W-1:0]       wr_data,
  output logic                    l2_we,
  output logic                    l3_we,
  output logic [$clog2(L2_N)-1:0] l2_idx,
  output logic [$clog2(L3_N)-1:0] l3_idx,
  output logic                    reject
);
  localparam int L2_IW = $clog2(L2_N);
  localparam int L3_IW = $clog2(L3_N);
  localparam logic [MASK_W-1:0] L2_DEF = MASK_W'((64'd1 << L2_LEN) - 64'd1);
  localparam logic [MASK_W-1:0] L3_DEF = MASK_W'((64'd1 << L3_LEN) - 64'd1);

  logic [ADDR_W-1:0] off2, off3;
  logic hit2, hit3, ok2, ok3, shape_ok;

  always_comb begin
    off2     = wr_addr - ADDR_W'(L2_BASE);
    off3     = wr_addr - ADDR_W'(L3_BASE);
    l2_idx   = off2[L2_IW-1:0];
    l3_idx   = off3[L3_IW-1:0];
    hit2     = (off2 < ADDR_W'(L2_N)) && (l2_idx != '0);
    hit3     = (off3 < ADDR_W'(L3_N)) && (l3_idx != '0);
    shape_ok = run_ok(32'(wr_data));
    ok2      = shape_ok && ((wr_data & ~L2_DEF) == '0);
    ok3      = shape_ok && ((wr_data & ~L3_DEF) == '0);
    l2_we    = wr_en && hit2 && ok2;
    l3_we    = wr_en && hit3 && ok3;
    reject   = wr_en && !(l2_we || l3_we);
  end

endmodule

// File: rtl/clos_mask_table.sv
module clos_mask_table #(
  parameter int L2_LEN  = 8,
  parameter int L3_LEN  = 12,
  parameter int L2_N    = 8,
  parameter int L3_N    = 16,
  parameter int ADDR_W  = 12,
  parameter int L2_BASE = 'hD10,
  parameter int L3_BASE = 'hC90
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          wr_en,
  input  logic [ADDR_W-1:0]                             wr_addr,
  input  logic [((L3_LEN > L2_LEN) ? L3_LEN : L2_LEN)-1:0] wr_data,
  input  logic                                          mode_wr,
  input  logic                                          mode_val,
  input  logic [$clog2((L3_N > L2_N) ? L3_N : L2_N)-1:0] lk_id,
  input  logic                                          lk_code,
  output logic [L2_LEN-1:0]                             l2_mask,
  output logic [L3_LEN-1:0]                             l3_mask,
  output logic                                          wr_err
);
  localparam int MASK_W = (L3_LEN > L2_LEN) ? L3_LEN : L2_LEN;
  localparam int ID_W   = $clog2((L3_N > L2_N) ? L3_N : L2_N);
  localparam int L2_IW  = $clog2(L2_N);
  localparam int L3_IW  = $clog2(L3_N);
  localparam logic [ID_W:0] L2_CNT  = (ID_W+1)'(L2_N);
  localparam logic [ID_W:0] L3_CNT  = (ID_W+1)'(L3_N);
  localparam logic [ID_W:0] L3_HALF = (ID_W+1)'(L3_N / 2);

  logic             l2_we, l3_we, reject;
  logic [L2_IW-1:0] l2_widx, l2_ridx;
  logic [L3_IW-1:0] l3_widx, l3_ridx;
  logic [L2_LEN-1:0] l2_rd;
  logic [L3_LEN-1:0] l3_rd;
  logic             split_q;
  logic [ID_W:0]    id_ext;
  logic             l2_use, l3_use;

  cmask_decode #(
    .ADDR_W(ADDR_W), .MASK_W(MASK_W), .L2_LEN(L2_LEN), .L3_LEN(L3_LEN),
    .L2_N(L2_N), .L3_N(L3_N), .L2_BASE(L2_BASE), .L3_BASE(L3_BASE)
  ) dec_i (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .l2_we(l2_we), .l3_we(l3_we), .l2_idx(l2_widx), .l3_idx(l3_widx),
    .reject(reject)
  );

  cmask_bank #(.W(L2_LEN), .DEPTH(L2_N)) l2_bank_i (
    .clk(clk), .rst(rst), .we(l2_we), .wr_idx(l2_widx),
    .wr_val(wr_data[L2_LEN-1:0]), .rd_idx(l2_ridx), .rd_val(l2_rd)
  );

  cmask_bank #(.W(L3_LEN), .DEPTH(L3_N)) l3_bank_i (
    .clk(clk), .rst(rst), .we(l3_we), .wr_idx(l3_widx),
    .wr_val(wr_data[L3_LEN-1:0]), .rd_idx(l3_ridx), .rd_val(l3_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      split_q <= 1'b0;
      wr_err  <= 1'b0;
    end else begin
      if (mode_wr) split_q <= mode_val;
      wr_err <= reject;
    end
  end

  always_comb begin
    id_ext  = {1'b0, lk_id};
    l2_ridx = lk_id[L2_IW-1:0];
    l3_ridx = split_q ? {lk_id[L3_IW-2:0], lk_code} : lk_id[L3_IW-1:0];
    l2_use  = (lk_id != '0) && (id_ext < L2_CNT);
    l3_use  = (lk_id != '0) && (id_ext < (split_q ? L3_HALF : L3_CNT));
    l2_mask = l2_use ? l2_rd : '1;
    l3_mask = l3_use ? l3_rd : '1;
  end

  // R5
  bad_wr_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !l2_we && !l3_we) |=> wr_err);

  // R12
  quiet_err_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || l2_we || l3_we) |=> !wr_err);

  // R6
  id0_chk: assert property (@(posedge clk) disable iff (rst)
    (lk_id == '0) |-> (l2_mask == '1 && l3_mask == '1));

  // R8
  l2_range_chk: assert property (@(posedge clk) disable iff (rst)
    (id_ext >= L2_CNT) |-> (l2_mask == '1));

  // R10
  split_range_chk: assert property (@(posedge clk) disable iff (rst)
    (split_q && id_ext >= L3_HALF) |-> (l3_mask == '1));

  // R11
  mode_load_chk: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (split_q == $past(mode_val)));

endmodule

// File: tb/clos_mask_table_tb_top.sv
`timescale 1ns/1ps
module clos_mask_table_tb_top;
  localparam int L2N = 8, L3N = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, mode_wr = 1'b0, mode_val = 1'b0, lk_code = 1'b0;
  logic [11:0] wr_addr = '0, wr_data = '0;
  logic [3:0]  lk_id = '0;
  logic [7:0]  l2_mask;
  logic [11:0] l3_mask;
  logic        wr_err;

  always #4 clk = ~clk;

  clos_mask_table dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode_wr(mode_wr), .mode_val(mode_val), .lk_id(lk_id), .lk_code(lk_code),
    .l2_mask(l2_mask), .l3_mask(l3_mask), .wr_err(wr_err)
  );

  typedef struct {
    bit          is_err;
    logic [7:0]  e2;
    logic [11:0] e3;
    logic        eerr;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0]  m2 [L2N];
  logic [11:0] m3 [L3N];
  bit split_m = 0;

  function automatic bit legal(input logic [11:0] d, input int len);
    int runs = 0;
    for (int i = 0; i < 12; i++) begin
      if (d[i] && (i == 0 || !d[i-1])) runs++;
      if (d[i] && i >= len) return 0;
    end
    return runs == 1;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [11:0] d, input string tag);
    bit ok = 0;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (a > 12'hC90 && a < 12'hC90 + L3N && legal(d, 12)) begin
      m3[a - 12'hC90] = d; ok = 1;
    end else if (a > 12'hD10 && a < 12'hD10 + L2N && legal(d, 8)) begin
      m2[a - 12'hD10] = d[7:0]; ok = 1;
    end
    @(negedge clk);
    wr_en = 1'b0;
    #1 q.push_back('{1'b1, 8'h0, 12'h0, !ok, tag});
  endtask

  task automatic idle_chk(input string tag);
    @(negedge clk);
    #1 q.push_back('{1'b1, 8'h0, 12'h0, 1'b0, tag});
  endtask

  task automatic look(input int id, input bit code, input string tag);
    logic [7:0] e2; logic [11:0] e3;
    @(negedge clk);
    lk_id = 4'(id); lk_code = code;
    e2 = (id == 0 || id >= L2N) ? 8'hFF : m2[id];
    if (id == 0) e3 = 12'hFFF;
    else if (split_m) e3 = (id >= L3N/2) ? 12'hFFF : m3[2*id + int'(code)];
    else e3 = m3[id];
    #1 q.push_back('{1'b0, e2, e3, 1'b0, tag});
  endtask

  task automatic set_mode(input bit v);
    @(negedge clk);
    mode_wr = 1'b1; mode_val = v;
    @(negedge clk);
    mode_wr = 1'b0;
    split_m = v;
  endtask

  // monitor: pops expected items and compares them with the outputs
  initial begin
    item_t it;
    forever begin
      wait (q.size() != 0);
      it = q.pop_front();
      checks++;
      if (it.is_err) begin
        if (wr_err !== it.eerr) begin
          errors++;
          $display("FAIL %s wr_err=%b expected %b", it.tag, wr_err, it.eerr);
        end
      end else if (l2_mask !== it.e2 || l3_mask !== it.e3) begin
        errors++;
        $display("FAIL %s l2=%h l3=%h expected l2=%h l3=%h",
                 it.tag, l2_mask, l3_mask, it.e2, it.e3);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < L2N; i++) m2[i] = 8'hFF;
    for (int i = 0; i < L3N; i++) m3[i] = 12'hFFF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1 q.push_back('{1'b1, 8'h0, 12'h0, 1'b0, "R1 reset err"});
    look(1, 0, "R1 reset entry");
    look(15, 1, "R1 reset entry");
    look(5, 0, "R2 default masks");
    look(9, 0, "R2 default masks");
    wr(12'hC93, 12'h0F0, "R3 l3 write");
    look(3, 0, "R3 l3 readback");
    wr(12'hC9F, 12'hC00, "R3 l3 top entry");
    look(15, 0, "R3 l3 top entry");
    wr(12'hD13, 12'h03C, "R4 l2 write");
    look(3, 0, "R4 l2 readback");
    wr(12'hD17, 12'h080, "R4 l2 last entry");
    look(7, 0, "R4 l2 last entry");
    wr(12'hC95, 12'h505, "R5 split runs");
    wr(12'hC95, 12'h000, "R5 zero mask");
    wr(12'hD12, 12'h1F0, "R5 too wide for l2");
    look(5, 0, "R5 unchanged l3");
    look(2, 0, "R5 unchanged l2");
    idle_chk("R12 err clears");
    wr(12'hC90, 12'h00F, "R6 pinned l3");
    wr(12'hD10, 12'h00F, "R6 pinned l2");
    look(0, 0, "R6 id0 default");
    wr(12'hCA0, 12'h00F, "R7 unmapped");
    wr(12'hD18, 12'h00F, "R7 unmapped");
    wr(12'h000, 12'h001, "R7 unmapped");
    look(3, 0, "R7 nothing changed");
    wr(12'hC9C, 12'h00C, "R8 setup");
    look(12, 0, "R8 l2 default l3 stored");
    look(3, 1, "R9 flag ignored");
    look(12, 1, "R9 flag ignored");
    wr(12'hC96, 12'h00F, "R10 data reg");
    wr(12'hC97, 12'hF00, "R10 code reg");
    wr(12'hC91, 12'h0FF, "R10 reg1 setup");
    idle_chk("R12 err low after good write");
    look(1, 0, "R11 plain view reg1");
    set_mode(1);
    look(3, 0, "R10 data select");
    look(3, 1, "R10 code select");
    look(7, 1, "R10 code select");
    look(0, 1, "R6 id0 in split");
    look(12, 0, "R10 upper half default");
    look(8, 1, "R10 upper half default");
    set_mode(0);
    look(3, 0, "R11 stored intact");
    look(6, 1, "R11 stored intact");
    wr(12'hC94, 12'hE07, "R5 wrap pattern");
    look(4, 0, "R5 wrap unchanged");
    wait (q.size() == 0);
    #2;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule